// File: doc/BRIEF.md
# Block Exponent Detector and Normalizer

This block prepares a block of interval samples for block floating point arithmetic. Each sample is an interval made of a lower and an upper endpoint, both 16-bit two's complement. The block sees every sample twice. During the detection pass it measures, for every endpoint, how many redundant sign bits sit below the sign bit, and keeps the smallest such count seen in the block. During the normalization pass it shifts both endpoints of every sample left by that one common amount, so that the block uses as much of the word as it can without any endpoint changing sign.

The common shift is folded into the block exponent: the exponent presented with the first sample of the detection pass is reduced by the shift, and the result is reported with a one-cycle done pulse once the last normalized sample has left. A block of N intervals takes N accepted samples for detection and N more for normalization. The block holds no sample storage; the caller replays the block for the second pass.

Top module: `bfn_block_norm`

## Requirements
- R1: The redundant sign bit count of an endpoint is the number of bits directly below the most significant bit that equal it (0 to W-1); 0x0000 and 0xFFFF both count W-1.
- R2: The shift of a block is the smallest redundant sign bit count over every lower and upper endpoint accepted during that block's detection pass.
- R3: When the detection pass ends (in_valid and in_last high during detection), exp_out becomes exp_in, as sampled with the block's first detection sample, minus the shift, in EXP_W-bit two's complement; it then holds through the normalization pass.
- R4: Each sample accepted during the normalization pass appears one cycle later on out_lo and out_hi, each shifted left by the block shift with zeros filled in, with out_valid high and out_last copying in_last; the sign bit is kept.
- R5: A block whose endpoints are all zero gets a shift of 0 and leaves exp_out equal to exp_in.
- R6: Samples accepted during the detection pass produce no output: out_valid stays low.
- R7: done is high for exactly one cycle, the cycle after the last normalized sample is on the output.
- R8: After a synchronous reset, out_valid, out_last, done, out_lo, out_hi and exp_out are zero and the block waits in the detection pass.
- R9: The running minimum restarts at W-1 for each new block, so a block's shift depends on no earlier block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_last | input | 1 | Final sample of the current pass |
| in_lo | input | W | Lower endpoint, two's complement |
| in_hi | input | W | Upper endpoint, two's complement |
| exp_in | input | EXP_W | Block exponent before normalization |
| out_valid | output | 1 | Normalized sample present |
| out_last | output | 1 | Final normalized sample of the block |
| out_lo | output | W | Normalized lower endpoint |
| out_hi | output | W | Normalized upper endpoint |
| exp_out | output | EXP_W | Block exponent after normalization |
| done | output | 1 | One-cycle pulse after the block ends |

## Verification
The bench builds the block with W = 16 and EXP_W = 8, which brings the full shift range of 0 to 15 within reach, including the all-ones block that shifts by the maximum and exponents that wrap below zero. Blocks are chosen so that the minimum comes from a lower endpoint in one and an upper endpoint in another, from a negative value, and from a lone significant sample among zeros. A block with shift 0 is followed by one with a large shift to show the minimum restarting, and an all-zero block and a single-sample block cover the edges of the count.

// File: rtl/bfn_pkg.sv
package bfn_pkg;
  typedef enum logic {
    PH_DETECT = 1'b0,
    PH_NORM   = 1'b1
  } phase_t;
endpackage

// File: rtl/bfn_sign_count.sv
module bfn_sign_count #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  d,
  output logic [CW-1:0] cnt,
  output logic          nz
);
  logic [W-2:0] diff;
  int           c;

  assign diff = d[W-1:1] ^ d[W-2:0];
  assign nz   = |d;

  // priority encoder: the highest sign change decides the count
  always_comb begin
    c = W - 1;
    for (int i = 0; i < W - 1; i++) begin
      if (diff[i]) c = W - 2 - i;
    end
    cnt = CW'(c);
  end
endmodule

// File: rtl/bfn_min_track.sv
module bfn_min_track #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          last,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic          nz_a,
  input  logic          nz_b,
  output logic [CW-1:0] cur_min,
  output logic          cur_nz
);
  localparam logic [CW-1:0] MAXC = CW'(W - 1);

  logic [CW-1:0] min_r;
  logic          nz_r;
  logic [CW-1:0] pair_min;

  assign pair_min = (cnt_a < cnt_b) ? cnt_a : cnt_b;
  assign cur_min  = (min_r < pair_min) ? min_r : pair_min;
  assign cur_nz   = nz_r | nz_a | nz_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      min_r <= MAXC;
      nz_r  <= 1'b0;
    end else if (take) begin
      if (last) begin
        min_r <= MAXC;
        nz_r  <= 1'b0;
      end else begin
        min_r <= cur_min;
        nz_r  <= cur_nz;
      end
    end
  end
endmodule

// File: rtl/bfn_lshift.sv
module bfn_lshift #(
  parameter int W  = 16,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  d,
  input  logic [CW-1:0] amt,
  output logic [W-1:0]  q
);
  logic [W-1:0] copies [W];

  for (genvar k = 0; k < W; k++) begin : g_copy
    assign copies[k] = d << k;
  end

  assign q = (int'(amt) < W) ? copies[amt] : '0;
endmodule

// File: rtl/bfn_block_norm.sv
module bfn_block_norm #(
  parameter int W     = 16,
  parameter int EXP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [W-1:0]     in_lo,
  input  logic [W-1:0]     in_hi,
  input  logic [EXP_W-1:0] exp_in,
  output logic             out_valid,
  output logic             out_last,
  output logic [W-1:0]     out_lo,
  output logic [W-1:0]     out_hi,
  output logic [EXP_W-1:0] exp_out,
  output logic             done
);
  import bfn_pkg::*;
  localparam int CW = $clog2(W);

  phase_t           phase;
  logic             norm_phase;
  logic             first_r;
  logic [EXP_W-1:0] base_r;
  logic [CW-1:0]    shift_r;
  logic [CW-1:0]    cnt_lo, cnt_hi, cur_min, shift_new;
  logic             nz_lo, nz_hi, cur_nz;
  logic             det_take, norm_take;
  logic [EXP_W-1:0] exp_now;
  logic [W-1:0]     sh_lo, sh_hi;

  assign norm_phase = (phase == PH_NORM);
  assign det_take   = in_valid && !norm_phase;
  assign norm_take  = in_valid && norm_phase;
  assign exp_now    = first_r ? exp_in : base_r;
  assign shift_new  = cur_nz ? cur_min : '0;

  bfn_sign_count #(.W(W), .CW(CW)) u_cnt_lo (.d(in_lo), .cnt(cnt_lo), .nz(nz_lo));
  bfn_sign_count #(.W(W), .CW(CW)) u_cnt_hi (.d(in_hi), .cnt(cnt_hi), .nz(nz_hi));

  bfn_min_track #(.W(W), .CW(CW)) u_min (
    .clk(clk), .rst(rst), .take(det_take), .last(in_last),
    .cnt_a(cnt_lo), .cnt_b(cnt_hi), .nz_a(nz_lo), .nz_b(nz_hi),
    .cur_min(cur_min), .cur_nz(cur_nz)
  );

  bfn_lshift #(.W(W), .CW(CW)) u_sh_lo (.d(in_lo), .amt(shift_r), .q(sh_lo));
  bfn_lshift #(.W(W), .CW(CW)) u_sh_hi (.d(in_hi), .amt(shift_r), .q(sh_hi));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_DETECT;
      first_r   <= 1'b1;
      base_r    <= '0;
      shift_r   <= '0;
      exp_out   <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_lo    <= '0;
      out_hi    <= '0;
      done      <= 1'b0;
    end else begin
      done      <= out_valid && out_last;
      out_valid <= norm_take;
      out_last  <= norm_take && in_last;
      if (det_take) begin
        if (first_r) base_r <= exp_in;
        first_r <= 1'b0;
        if (in_last) begin
          phase   <= PH_NORM;
          first_r <= 1'b1;
          shift_r <= shift_new;
          exp_out <= exp_now - EXP_W'(shift_new);
        end
      end
      if (norm_take) begin
        out_lo <= sh_lo;
        out_hi <= sh_hi;
        if (in_last) phase <= PH_DETECT;
      end
    end
  end
endmodule

// File: rtl/bfn_block_norm_chk.sv
module bfn_block_norm_chk #(
  parameter int W     = 16,
  parameter int EXP_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_last,
  input logic [W-1:0]     in_lo,
  input logic [W-1:0]     in_hi,
  input logic             norm_phase,
  input logic             out_valid,
  input logic             out_last,
  input logic [W-1:0]     out_lo,
  input logic [W-1:0]     out_hi,
  input logic [EXP_W-1:0] exp_out,
  input logic             done
);
  // R4: the sign of each endpoint survives the shift
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_lo[W-1] == $past(in_lo[W-1]) && out_hi[W-1] == $past(in_hi[W-1])));

  // R6: a detection-pass sample yields no output
  a_r6_quiet_detect: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !norm_phase) |=> !out_valid);

  // R7: done follows the last normalized sample
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_last));

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: exponent is steady while normalized data flows
  a_r3_exp_steady: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $stable(exp_out));

  // R8: reset clears the output flags
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !done));
endmodule

bind bfn_block_norm bfn_block_norm_chk #(.W(W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
  .in_lo(in_lo), .in_hi(in_hi), .norm_phase(norm_phase),
  .out_valid(out_valid), .out_last(out_last), .out_lo(out_lo),
  .out_hi(out_hi), .exp_out(exp_out), .done(done)
);

// File: tb/bfn_block_norm_bench.sv
module bfn_block_norm_bench;
  localparam int W     = 16;
  localparam int EXP_W = 8;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid, in_last;
  logic [W-1:0]     in_lo, in_hi;
  logic [EXP_W-1:0] exp_in;
  logic             out_valid, out_last, done;
  logic [W-1:0]     out_lo, out_hi;
  logic [EXP_W-1:0] exp_out;

  int total = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bfn_block_norm #(.W(W), .EXP_W(EXP_W)) u_bfn_block_norm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
    .in_lo(in_lo), .in_hi(in_hi), .exp_in(exp_in),
    .out_valid(out_valid), .out_last(out_last), .out_lo(out_lo),
    .out_hi(out_hi), .exp_out(exp_out), .done(done)
  );

  // {lo0, hi0, lo1, hi1, exp_in, expected shift}
  localparam logic [79:0] VEC [6] = '{
    {16'h0100, 16'h4000, 16'hFF00, 16'h0010, 8'h05, 8'd0},
    {16'h0004, 16'h0030, 16'hFFF3, 16'h0001, 8'h00, 8'd9},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'h03, 8'd15},
    {16'h0000, 16'h0000, 16'h0000, 16'h0001, 8'h0A, 8'd14},
    {16'hC000, 16'h2000, 16'h0000, 16'h1000, 8'hFE, 8'd1},
    {16'h0001, 16'h0800, 16'h0001, 16'h0002, 8'h07, 8'd3}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] shl(input logic [15:0] v, input int s);
    return v << s;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic drive(input logic v, input logic [15:0] lo, input logic [15:0] hi, input logic last);
    in_valid = v; in_lo = lo; in_hi = hi; in_last = last;
    @(negedge clk);
  endtask

  task automatic run_block(input int n, input logic [15:0] la [8], input logic [15:0] ha [8],
                           input logic [7:0] e, input int sh, input string tag);
    logic [7:0] ee;
    ee = e - 8'(sh);
    exp_in = e;
    for (int i = 0; i < n; i++) begin
      drive(1'b1, la[i], ha[i], i == n - 1);
      check({tag, " R6 no output in detection"}, {31'd0, out_valid}, 32'd0);
    end
    for (int i = 0; i < n; i++) begin
      drive(1'b1, la[i], ha[i], i == n - 1);
      check({tag, " R4 out_valid"}, {31'd0, out_valid}, 32'd1);
      check({tag, " R1 R2 R4 out_lo"}, {16'd0, out_lo}, {16'd0, shl(la[i], sh)});
      check({tag, " R1 R2 R4 out_hi"}, {16'd0, out_hi}, {16'd0, shl(ha[i], sh)});
      check({tag, " R4 out_last"}, {31'd0, out_last}, {31'd0, i == n - 1});
    end
    exp_in = 8'h55;
    drive(1'b0, 16'h0, 16'h0, 1'b0);
    check({tag, " R7 done pulse"}, {31'd0, done}, 32'd1);
    check({tag, " R3 R5 exp_out"}, {24'd0, exp_out}, {24'd0, ee});
    check({tag, " R6 idle output"}, {31'd0, out_valid}, 32'd0);
    drive(1'b0, 16'h0, 16'h0, 1'b0);
    check({tag, " R7 done single"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] la [8];
    logic [15:0] ha [8];
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_lo = '0; in_hi = '0; exp_in = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 out_valid", {31'd0, out_valid}, 32'd0);
    check("R8 done", {31'd0, done}, 32'd0);
    check("R8 exp_out", {24'd0, exp_out}, 32'd0);
    check("R8 out_lo", {16'd0, out_lo}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // table walk; block order also shows R9 (shift 0 followed by shift 9)
    for (int v = 0; v < 6; v++) begin
      for (int k = 0; k < 8; k++) begin la[k] = '0; ha[k] = '0; end
      la[0] = VEC[v][79:64]; ha[0] = VEC[v][63:48];
      la[1] = VEC[v][47:32]; ha[1] = VEC[v][31:16];
      run_block(2, la, ha, VEC[v][15:8], int'(VEC[v][7:0]), $sformatf("vec%0d R9", v));
    end

    // R5: all-zero block keeps the exponent
    for (int k = 0; k < 8; k++) begin la[k] = '0; ha[k] = '0; end
    run_block(3, la, ha, 8'h09, 0, "zero block R5");

    // single-sample block, negative exponent wraps
    la[0] = 16'h0008; ha[0] = 16'hFFF0;
    run_block(1, la, ha, 8'hFF, 11, "single R2");

    // five-sample block with the minimum on the last upper endpoint
    la[0] = 16'h0001; ha[0] = 16'h0002;
    la[1] = 16'hFFFE; ha[1] = 16'h0003;
    la[2] = 16'h0000; ha[2] = 16'h0010;
    la[3] = 16'hFFFF; ha[3] = 16'h0001;
    la[4] = 16'h0004; ha[4] = 16'h0200;
    run_block(5, la, ha, 8'h20, 5, "long R2");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule